// File: doc/BRIEF.md
# Elapsed-Time Counter With Automatic Rate Drop

This block keeps the elapsed time of one current direction. It is meant for charge time or discharge time in a battery monitor. The enclosing logic asserts a direction-active input while current flows the way this counter tracks. A fast time-base tick advances a base prescaler. In normal mode every completed base period adds one to a counter of `CNT_W` bits. For the intended clock plan, one base period is 0.8789 s, which is 4096 counts per hour. The count is presented as an upper half and a lower half.

When the counter steps past its all-ones value, it wraps to zero and raises a slow-mode flag. While that flag is high, a second prescaler of `SLOW_W` bits stands between the base period and the counter. The count rate therefore drops by a factor of 2^`SLOW_W`. With the default of 8 bits, that is one count per 225 s, or 16 per hour. A further wrap lowers the flag again, which returns the counter to the normal rate. A clear strobe zeroes the count. The flag can also be written directly, and the new rate applies from the next count onward. A sleep input freezes all counting. All pins are plain control and status signals, so no valid/ready handshake or back-pressure applies at this boundary.

Top module: `tc_time_counter`

## Requirements
- R1: After reset the count is 0 and the slow-mode flag is 0.
- R2: With the flag at 0, the count rises by exactly one on every `BASE_DIV`-th cycle where tick, direction-active and not-sleep are all true. Cycles that lack any of these three conditions do not count.
- R3: While direction-active is low, the count and both prescalers hold their values.
- R4: While sleep is high, the count and both prescalers hold their values, even when tick and direction-active are high.
- R5: A step from the all-ones count wraps the count to 0. When the flag was 0, the same step sets the flag to 1.
- R6: With the flag at 1, the count rises by one per 2^`SLOW_W` base periods. The slow prescaler restarts from zero at every change of the flag.
- R7: A wrap while the flag is 1 clears the flag, and the following counts come at the normal rate.
- R8: A clear strobe sets the count to 0 on the next edge. It leaves the flag unchanged.
- R9: When clear and a wrap fall in the same cycle, clear wins: the count becomes 0 and the flag does not toggle.
- R10: A flag write loads `flag_wdata` into the flag on the next edge. The next count comes at the rate that matches the written value.
- R11: When a flag write and a wrap fall in the same cycle, the written value wins over the toggle, and the count still wraps to 0.
- R12: `count_hi` carries bits [CNT_W-1:CNT_W/2] of the count and `count_lo` carries bits [CNT_W/2-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Fast time-base pulse |
| dir_active | input | 1 | High while the tracked current direction is present |
| sleep | input | 1 | Freezes all counting while high |
| clear | input | 1 | Single-cycle strobe that zeroes the count |
| flag_wr | input | 1 | Direct write strobe for the slow-mode flag |
| flag_wdata | input | 1 | Value loaded into the flag on a write |
| count_hi | output | CNT_W/2 | Upper half of the count |
| count_lo | output | CNT_W/2 | Lower half of the count |
| slow_flag | output | 1 | Slow-mode flag; 1 means the reduced rate is active |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a rollover and a clear strobe. The second pair is a rollover and a direct flag write.

The bench keeps its own model of the base prescaler phase. From that model it knows the exact cycle in which the all-ones count will step. It then drives either the clear strobe or the flag write in that cycle. The outcome is judged at the ports on the next sample:
- With the clear strobe, the count must read zero and the flag must be unchanged.
- With the flag write, the count must read zero and the flag must hold the written value rather than the toggled one.

// File: rtl/tc_pkg.sv
package tc_pkg;
  // Control strobes that act on the count register.
  typedef struct packed {
    logic clear;
    logic wr;
    logic wdata;
  } tc_ctl_t;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_SLOW   = 1'b1
  } tc_mode_e;
endpackage

// File: rtl/tc_div.sv
// Pulse divider: emits one output pulse for every DIV input pulses.
module tc_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic pulse_in,
  output logic pulse_out
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

  logic [W-1:0] phase;

  assign pulse_out = pulse_in && (phase == LAST);

  generate
    if (POW2) begin : g_wrap
      always_ff @(posedge clk) begin
        if (!rst_n || restart) phase <= '0;
        else if (pulse_in)     phase <= phase + 1'b1;
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        if (!rst_n || restart) phase <= '0;
        else if (pulse_in)     phase <= (phase == LAST) ? '0 : phase + 1'b1;
      end
    end
  endgenerate

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0));
  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_in && !restart) |=> $stable(phase));
endmodule

// File: rtl/tc_count.sv
// Count register and slow-mode flag with wrap, clear and direct write.
module tc_count
  import tc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  tc_ctl_t          ctl,
  output logic [CNT_W-1:0] cnt,
  output tc_mode_e         mode,
  output logic             mode_chg
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic     wrap;
  tc_mode_e mode_nxt;

  assign wrap = step && !ctl.clear && (cnt == ALL_ONES);

  always_comb begin
    mode_nxt = mode;
    if (ctl.wr)    mode_nxt = tc_mode_e'(ctl.wdata);
    else if (wrap) mode_nxt = (mode == MODE_NORMAL) ? MODE_SLOW : MODE_NORMAL;
  end

  assign mode_chg = (mode_nxt != mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      mode <= MODE_NORMAL;
    end else begin
      mode <= mode_nxt;
      if (ctl.clear)  cnt <= '0;
      else if (step)  cnt <= cnt + 1'b1;
    end
  end

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clear |=> (cnt == '0));
  // R5
  wrap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ctl.clear && !ctl.wr && cnt == ALL_ONES) |=> (cnt == '0 && mode != $past(mode)));
  // R10
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wr |=> (mode == tc_mode_e'($past(ctl.wdata))));
  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.clear |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/tc_time_counter.sv
module tc_time_counter
  import tc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BASE_DIV = 4,
  parameter int SLOW_W   = 8,
  localparam int HALF    = CNT_W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            dir_active,
  input  logic            sleep,
  input  logic            clear,
  input  logic            flag_wr,
  input  logic            flag_wdata,
  output logic [HALF-1:0] count_hi,
  output logic [HALF-1:0] count_lo,
  output logic            slow_flag
);
  localparam int SLOW_DIV = 1 << SLOW_W;

  logic             advance;
  logic             base_pulse;
  logic             slow_pulse;
  logic             step;
  logic             mode_chg;
  logic [CNT_W-1:0] cnt;
  tc_mode_e         mode;
  tc_ctl_t          ctl;

  assign advance = tick && dir_active && !sleep;
  assign ctl     = '{clear: clear, wr: flag_wr, wdata: flag_wdata};

  tc_div #(.DIV(BASE_DIV)) u_base (
    .clk(clk), .rst_n(rst_n), .restart(1'b0),
    .pulse_in(advance), .pulse_out(base_pulse)
  );

  tc_div #(.DIV(SLOW_DIV)) u_slow (
    .clk(clk), .rst_n(rst_n), .restart(mode_chg),
    .pulse_in(base_pulse && mode == MODE_SLOW), .pulse_out(slow_pulse)
  );

  assign step = (mode == MODE_SLOW) ? slow_pulse : base_pulse;

  tc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .ctl(ctl),
    .cnt(cnt), .mode(mode), .mode_chg(mode_chg)
  );

  assign count_hi  = cnt[CNT_W-1:HALF];
  assign count_lo  = cnt[HALF-1:0];
  assign slow_flag = (mode == MODE_SLOW);

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_active && !clear) |=> $stable({count_hi, count_lo}));
  // R4
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !clear) |=> $stable({count_hi, count_lo}));
  // R9
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !flag_wr) |=> $stable(slow_flag));
endmodule

// File: tb/sim_tc_time_counter.sv
module sim_tc_time_counter;
  localparam int CW = 8, BD = 3, SW = 2, SD = 4, HW = 4, MAXC = 255;

  logic clk = 0, rst_n = 0;
  logic tick = 0, dir = 0, slp = 0, clr = 0, wr = 0, wv = 0;
  logic [HW-1:0] c_hi, c_lo;
  logic flag;
  int checks = 0, errors = 0;
  int m_cnt = 0, m_base = 0, m_slow = 0;
  bit m_flag = 0;

  always #4 clk = ~clk;

  tc_time_counter #(.CNT_W(CW), .BASE_DIV(BD), .SLOW_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dir_active(dir), .sleep(slp),
    .clear(clr), .flag_wr(wr), .flag_wdata(wv),
    .count_hi(c_hi), .count_lo(c_lo), .slow_flag(flag)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected behaviour derived from the requirements.
  task automatic model();
    bit adv, bp, sp, stp, nf;
    adv = tick && dir && !slp;
    bp = adv && (m_base == BD - 1);
    if (adv) m_base = bp ? 0 : m_base + 1;
    sp = bp && m_flag && (m_slow == SD - 1);
    stp = m_flag ? sp : bp;
    nf = m_flag;
    if (wr) nf = wv;
    else if (stp && !clr && m_cnt == MAXC) nf = !m_flag;
    if (nf != m_flag) m_slow = 0;
    else if (bp && m_flag) m_slow = (m_slow == SD - 1) ? 0 : m_slow + 1;
    m_flag = nf;
    if (clr) m_cnt = 0;
    else if (stp) m_cnt = (m_cnt + 1) % (MAXC + 1);
  endtask

  task automatic cyc(bit t, bit d, bit s, bit c, bit w, bit v, string req);
    @(negedge clk);
    tick = t; dir = d; slp = s; clr = c; wr = w; wv = v;
    @(posedge clk);
    model();
    #2;
    check(req, {c_hi, c_lo}, m_cnt);
    check(req, flag, m_flag);
  endtask

  // Run counting until the next step lands on the all-ones value.
  task automatic run_to_edge(string req);
    while (!(m_cnt == MAXC && m_base == BD - 1 && (!m_flag || m_slow == SD - 1)))
      cyc(1, 1, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", {c_hi, c_lo}, 0);
    check("R1", flag, 0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 20; i++) cyc(i % 2, 1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 10; i++) cyc(1, 1, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 60; i++) cyc(1, 1, 0, 0, 0, 0, "R12");
    check("R12", c_hi, m_cnt / 16);
    check("R12", c_lo, m_cnt % 16);
    run_to_edge("R2");
    cyc(1, 1, 0, 1, 0, 0, "R9");
    check("R9", flag, 0);
    run_to_edge("R2");
    cyc(1, 1, 0, 0, 0, 0, "R5");
    check("R5", flag, 1);
    check("R5", {c_hi, c_lo}, 0);
    for (int i = 0; i < 100; i++) cyc(1, 1, 0, 0, 0, 0, "R6");
    check("R6", {c_hi, c_lo}, 100 / (BD * SD));
    cyc(0, 1, 0, 1, 0, 0, "R8");
    check("R8", flag, 1);
    cyc(0, 1, 0, 0, 1, 0, "R10");
    for (int i = 0; i < 9; i++) cyc(1, 1, 0, 0, 0, 0, "R10");
    cyc(0, 1, 0, 0, 1, 1, "R10");
    for (int i = 0; i < 30; i++) cyc(1, 1, 0, 0, 0, 0, "R6");
    run_to_edge("R6");
    cyc(1, 1, 0, 0, 0, 0, "R7");
    check("R7", flag, 0);
    for (int i = 0; i < 12; i++) cyc(1, 1, 0, 0, 0, 0, "R7");
    run_to_edge("R2");
    cyc(1, 1, 0, 0, 1, 0, "R11");
    check("R11", flag, 0);
    check("R11", {c_hi, c_lo}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule